// File: doc/BRIEF.md
# Minimal 16-bit Load/Store Processor Core

A single-issue 16-bit core with one port for instruction fetch and one port for data. Fetch drives a byte address to a synchronous instruction ROM that has one cycle of read latency. The ROM returns a 16-bit word one cycle later. Because of that latency, fetch always runs one address ahead of execute.

The core has sixteen 16-bit registers. Register 14 is the program counter and is an ordinary register-file entry. Any instruction that writes it performs a jump. Reading it as an operand yields the address of the instruction that follows the one executing. Every instruction holds a 4-bit opcode in bits [15:12] and nibble-wide register fields.

Data accesses use combinational strobes: a read strobe and a write strobe. An access completes in the cycle its strobe is high. A busy input freezes the whole core, including fetch, for as long as it is high.

Top module: `cpu_core`

## Requirements
- R1: While `rst_ni` is low and just after it rises, `code_addr_o` is 0x0000 and both data strobes are low. All registers and the equality flag start at zero.
- R2: In each cycle without busy and without a redirect, `code_addr_o` advances by 2. The first two edges after reset give 0x0002, then 0x0004. `code_addr_o[0]` is always 0.
- R3: The opcode is `ir[15:12]`. The word 0x0000 does nothing. Opcodes other than 0x1, 0x2, 0x3, 0xC, 0xD and 0xE also act as no-operations and change no register.
- R4: SET (0xE) writes the zero-extended `ir[7:0]` into register `ir[11:8]`. For example, 0xE02A puts 42 in r0.
- R5: ADD (0x3) writes `reg[ir[7:4]] + reg[ir[3:0]]`, modulo 2^16, into register `ir[11:8]`.
- R6: STORE (0x2) raises `data_wr_o` for one cycle. In that cycle `data_addr_o` = `reg[ir[7:4]]` and `data_wdata_o` = `reg[ir[11:8]]`.
- R7: LOAD (0x1) raises `data_rd_o` for one cycle with `data_addr_o` = `reg[ir[7:4]]`. It writes `data_rdata_i`, sampled in that cycle, into register `ir[11:8]`.
- R8: CMP (0xC) sets the equality flag to (`reg[ir[11:8]] == reg[ir[7:4]]`). The flag is changed by no other instruction.
- R9: BR (0xD) is taken only when the flag is set. The target is the address of the next instruction plus 2 × sign-extended `ir[7:0]`. A negative offset branches backwards.
- R10: Writing r14 jumps to the written value with bit 0 cleared. Reading r14 gives the address of the next instruction. On a jump or a taken branch, the word already prefetched is discarded and does not execute.
- R11: While `data_busy_i` is high, both strobes stay low. `code_addr_o` holds in the following cycle, and no architectural state changes. Execution resumes unchanged after busy falls.
- R12: `data_rd_o` and `data_wr_o` are never high together. Both are low for instructions that do not access memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_addr_o | output | 16 | Fetch byte address (the program counter) |
| code_data_i | input | 16 | Instruction word, returned one cycle after its address |
| data_addr_o | output | 16 | Data access address |
| data_wdata_o | output | 16 | Store data |
| data_rdata_i | input | 16 | Load data, sampled in the read-strobe cycle |
| data_rd_o | output | 1 | Read strobe |
| data_wr_o | output | 1 | Write strobe |
| data_busy_i | input | 1 | Stall request; freezes the core while high |

## Verification
The assertions assume three things about the environment:
- the ROM returns the word for the previous cycle's address;
- busy is only changed between clock edges;
- load data is valid combinationally in the read-strobe cycle.

The bench meets these as follows:
- its ROM model registers `code_data_i` from `code_addr_o` on each edge;
- its data memory answers reads combinationally from an array;
- it drives busy and reset one nanosecond after the rising edge and samples outputs on the falling edge.

Busy pulses are placed at fixed cycle offsets, so they land on both memory and non-memory instructions. The results of those runs must match the runs without busy.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int unsigned ILEN = 16;

  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_LOAD  = 4'h1,
    OP_STORE = 4'h2,
    OP_ADD   = 4'h3,
    OP_CMP   = 4'hC,
    OP_BR    = 4'hD,
    OP_SET   = 4'hE
  } opcode_e;

  typedef struct packed {
    logic       is_load;
    logic       is_store;
    logic       is_add;
    logic       is_cmp;
    logic       is_br;
    logic       is_set;
    logic [3:0] rd;
    logic [3:0] ra;
    logic [3:0] rb;
    logic [7:0] imm;
  } dec_t;
endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
  import cpu_pkg::*;
(
  input  logic [ILEN-1:0] ir_i,
  output dec_t            dec_o
);
  always_comb begin
    dec_o     = '0;
    dec_o.rd  = ir_i[11:8];
    dec_o.ra  = ir_i[7:4];
    dec_o.rb  = ir_i[3:0];
    dec_o.imm = ir_i[7:0];
    case (opcode_e'(ir_i[15:12]))
      OP_LOAD:  dec_o.is_load  = 1'b1;
      OP_STORE: dec_o.is_store = 1'b1;
      OP_ADD:   dec_o.is_add   = 1'b1;
      OP_CMP:   dec_o.is_cmp   = 1'b1;
      OP_BR:    dec_o.is_br    = 1'b1;
      OP_SET:   dec_o.is_set   = 1'b1;
      default:  ; // unused opcodes behave as no-ops
    endcase
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int unsigned DW     = 16,
  parameter int unsigned NREG   = 16,
  parameter int unsigned PC_IDX = 14,
  localparam int unsigned AW    = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr0_i,
  input  logic [AW-1:0] raddr1_i,
  output logic [DW-1:0] rdata0_o,
  output logic [DW-1:0] rdata1_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pc_we_i,
  input  logic [DW-1:0] pc_d_i,
  output logic [DW-1:0] pc_o
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == PC_IDX) begin : g_pc
      // pc entry takes its full next value from the pc unit
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      regs[i] <= '0;
        else if (pc_we_i) regs[i] <= pc_d_i;
      end
    end else begin : g_gp
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            regs[i] <= '0;
        else if (we_i && waddr_i == AW'(i))     regs[i] <= wdata_i;
      end
    end
  end

  assign rdata0_o = regs[raddr0_i];
  assign rdata1_o = regs[raddr1_i];
  assign pc_o     = regs[PC_IDX];
endmodule

// File: rtl/cpu_pc_next.sv
module cpu_pc_next #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] pc_i,
  input  logic          br_taken_i,
  input  logic [7:0]    off_i,
  input  logic          pc_wr_i,
  input  logic [DW-1:0] pc_wdata_i,
  output logic [DW-1:0] pc_d_o
);
  logic [DW-1:0] br_delta;
  assign br_delta = {{(DW-9){off_i[7]}}, off_i, 1'b0};

  always_comb begin
    if (br_taken_i)   pc_d_o = pc_i + br_delta;
    else if (pc_wr_i) pc_d_o = {pc_wdata_i[DW-1:1], 1'b0};
    else              pc_d_o = pc_i + DW'(2);
  end
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned NREG   = 16,
  parameter int unsigned PC_IDX = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [DW-1:0]   code_addr_o,
  input  logic [ILEN-1:0] code_data_i,
  output logic [DW-1:0]   data_addr_o,
  output logic [DW-1:0]   data_wdata_o,
  input  logic [DW-1:0]   data_rdata_i,
  output logic            data_rd_o,
  output logic            data_wr_o,
  input  logic            data_busy_i
);
  localparam int unsigned AW = $clog2(NREG);

  logic            valid_q, held_q, eq_q;
  logic [ILEN-1:0] ir_q, ir;
  dec_t            dec;
  logic            go, rf_we, pc_wr, br_taken, redirect;
  logic [AW-1:0]   raddr0, raddr1;
  logic [DW-1:0]   rdata0, rdata1, wdata, pc, pc_d;

  // while stalled the ROM already shows the next word, so keep our own copy
  assign ir = held_q ? ir_q : code_data_i;

  cpu_decode u_dec (.ir_i(ir), .dec_o(dec));

  assign go     = valid_q & ~data_busy_i;
  assign raddr0 = dec.is_add ? dec.rb[AW-1:0] : dec.rd[AW-1:0];
  assign raddr1 = dec.is_add ? dec.ra[AW-1:0] : dec.ra[AW-1:0];

  always_comb begin
    if (dec.is_set)      wdata = {{(DW-8){1'b0}}, dec.imm};
    else if (dec.is_add) wdata = rdata0 + rdata1;
    else                 wdata = data_rdata_i;
  end

  assign rf_we    = go & (dec.is_set | dec.is_add | dec.is_load);
  assign pc_wr    = rf_we & (dec.rd[AW-1:0] == AW'(PC_IDX));
  assign br_taken = go & dec.is_br & eq_q;
  assign redirect = br_taken | pc_wr;

  cpu_pc_next #(.DW(DW)) u_pcn (
    .pc_i(pc), .br_taken_i(br_taken), .off_i(dec.imm),
    .pc_wr_i(pc_wr), .pc_wdata_i(wdata), .pc_d_o(pc_d)
  );

  cpu_regfile #(.DW(DW), .NREG(NREG), .PC_IDX(PC_IDX)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .raddr0_i(raddr0), .raddr1_i(raddr1),
    .rdata0_o(rdata0), .rdata1_o(rdata1),
    .we_i(rf_we), .waddr_i(dec.rd[AW-1:0]), .wdata_i(wdata),
    .pc_we_i(~data_busy_i), .pc_d_i(pc_d), .pc_o(pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      held_q  <= 1'b0;
      ir_q    <= '0;
      eq_q    <= 1'b0;
    end else if (data_busy_i) begin
      held_q <= 1'b1;
      ir_q   <= ir;
    end else begin
      held_q  <= 1'b0;
      valid_q <= ~redirect; // drop the prefetched word on redirect
      if (go && dec.is_cmp) eq_q <= (rdata0 == rdata1);
    end
  end

  assign code_addr_o  = pc;
  assign data_addr_o  = rdata1;
  assign data_wdata_o = rdata0;
  assign data_rd_o    = go & dec.is_load;
  assign data_wr_o    = go & dec.is_store;
endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] code_addr_o,
  input logic          data_rd_o,
  input logic          data_wr_o,
  input logic          data_busy_i
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_rd_o && data_wr_o)); // R12

  AST_BUSY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_busy_i |-> (!data_rd_o && !data_wr_o)); // R11

  AST_BUSY_HOLD_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_busy_i |=> $stable(code_addr_o)); // R11

  AST_FETCH_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_addr_o[0] == 1'b0); // R2

  AST_BUSY_SINGLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({data_rd_o, data_wr_o, data_busy_i}) <= 1); // R12
endmodule

bind cpu_core cpu_core_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .code_addr_o(code_addr_o),
  .data_rd_o(data_rd_o), .data_wr_o(data_wr_o), .data_busy_i(data_busy_i)
);

// File: tb/tb_cpu_core.sv
module tb_cpu_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] code_addr_o, code_data_i, data_addr_o, data_wdata_o, data_rdata_i;
  logic        data_rd_o, data_wr_o;
  logic        data_busy_i = 1'b0;

  logic [15:0] rom  [64];
  logic [15:0] dmem [256];
  logic [15:0] st_a [16];
  logic [15:0] st_d [16];
  int          n_st, n_ld;
  logic [15:0] ld_a;
  bit          saw_1a, busy_prev;
  logic [15:0] addr_prev;
  int          checks = 0, fails = 0;

  always #2 clk_i = ~clk_i; // 250 MHz

  cpu_core dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_addr_o(code_addr_o), .code_data_i(code_data_i),
    .data_addr_o(data_addr_o), .data_wdata_o(data_wdata_o), .data_rdata_i(data_rdata_i),
    .data_rd_o(data_rd_o), .data_wr_o(data_wr_o), .data_busy_i(data_busy_i)
  );

  initial code_data_i = 16'h0000;
  always @(posedge clk_i) code_data_i <= rom[code_addr_o[6:1]];
  assign data_rdata_i = dmem[data_addr_o[7:0]];

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      check(!(data_rd_o && data_wr_o), "R12", {14'd0, data_rd_o, data_wr_o}, 16'h0);
      if (data_busy_i)
        check(!data_rd_o && !data_wr_o, "R11 strobes", {14'd0, data_rd_o, data_wr_o}, 16'h0);
      if (busy_prev)
        check(code_addr_o == addr_prev, "R11 fetch hold", code_addr_o, addr_prev);
      if (data_wr_o) begin
        dmem[data_addr_o[7:0]] = data_wdata_o;
        if (n_st < 16) begin
          st_a[n_st] = data_addr_o;
          st_d[n_st] = data_wdata_o;
        end
        n_st++;
      end
      if (data_rd_o) begin
        n_ld++;
        ld_a = data_addr_o;
      end
      if (code_addr_o == 16'h001A) saw_1a = 1'b1;
      busy_prev = data_busy_i;
      addr_prev = code_addr_o;
    end
  end

  task automatic clear_all();
    for (int i = 0; i < 64; i++) rom[i] = 16'h0000;
    for (int i = 0; i < 256; i++) dmem[i] = 16'h0000;
    n_st = 0; n_ld = 0; ld_a = 16'h0; saw_1a = 1'b0;
  endtask

  task automatic put(int addr, logic [15:0] w);
    rom[addr >> 1] = w;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    data_busy_i = 1'b0;
    busy_prev = 1'b0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    check(code_addr_o == 16'h0, "R1 fetch addr", code_addr_o, 16'h0);
    check(!data_rd_o && !data_wr_o, "R1 strobes", {14'd0, data_rd_o, data_wr_o}, 16'h0);
  endtask

  task automatic run(int n, bit with_busy);
    for (int c = 0; c < n; c++) begin
      @(posedge clk_i);
      #1 data_busy_i = with_busy && (c == 5 || c == 6 || c == 7 || c == 13 || c == 20);
    end
    @(posedge clk_i);
    #1 data_busy_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic load_p1();
    clear_all();
    put(16'h00, 16'h0000); // NOP
    put(16'h02, 16'hE02A); // SET r0,42
    put(16'h04, 16'hE125); // SET r1,0x25
    put(16'h06, 16'h2010); // STORE r0,[r1]
    put(16'h08, 16'h1210); // LOAD r2,[r1]
    put(16'h0A, 16'h3322); // ADD r3,r2,r2
    put(16'h0C, 16'h2310); // STORE r3,[r1]
    put(16'h0E, 16'hC020); // CMP r0,r2
    put(16'h10, 16'hD001); // BR +1
    put(16'h12, 16'hE355); // skipped
    put(16'h14, 16'h2310); // STORE r3,[r1]
    put(16'h16, 16'hEE30); // SET pc,0x30
    put(16'h18, 16'h2010); // prefetched, discarded
    put(16'h30, 16'h2E10); // STORE r14,[r1]
    put(16'h32, 16'hEE32); // self loop
  endtask

  task automatic check_p1(string tag);
    check(n_st == 4, {tag, " R10 store count"}, 16'(n_st), 16'd4);
    check(st_a[0] == 16'h25 && st_d[0] == 16'd42, {tag, " R6 store"}, st_d[0], 16'd42);
    check(n_ld == 1 && ld_a == 16'h25, {tag, " R7 load"}, ld_a, 16'h25);
    check(st_d[1] == 16'd84, {tag, " R5 R7 doubled"}, st_d[1], 16'd84);
    check(st_d[2] == 16'd84, {tag, " R8 R9 branch skip"}, st_d[2], 16'd84);
    check(st_d[3] == 16'h32, {tag, " R10 read pc"}, st_d[3], 16'h32);
    check(!saw_1a, {tag, " R10 flush"}, {15'd0, saw_1a}, 16'h0);
  endtask

  initial begin
    // directed program, no busy
    load_p1();
    do_reset();
    @(negedge clk_i);
    check(code_addr_o == 16'h0, "R1 before first edge", code_addr_o, 16'h0);
    @(negedge clk_i);
    check(code_addr_o == 16'h2, "R2 step1", code_addr_o, 16'h2);
    @(negedge clk_i);
    check(code_addr_o == 16'h4, "R2 step2", code_addr_o, 16'h4);
    run(50, 1'b0);
    check_p1("p1");

    // same program with busy pulses
    load_p1();
    do_reset();
    run(60, 1'b1);
    check_p1("p1 busy R11");

    // 16-bit wraparound of ADD
    begin
      logic [15:0] v;
      clear_all();
      put(16'h00, 16'hE1FF);
      for (int k = 0; k < 9; k++) put(2 + 2 * k, 16'h3111);
      put(16'h14, 16'h2100);
      put(16'h16, 16'hEE16);
      do_reset();
      run(40, 1'b0);
      v = 16'hFF;
      for (int k = 0; k < 9; k++) v = 16'(v * 2);
      check(n_st == 1 && st_d[0] == v, "R5 wrap", st_d[0], v);
      check(st_a[0] == 16'h0, "R1 r0 zero", st_a[0], 16'h0);
    end

    // backward branch loop
    clear_all();
    put(16'h00, 16'hE000);
    put(16'h02, 16'hE101);
    put(16'h04, 16'hE203);
    put(16'h06, 16'h3001);
    put(16'h08, 16'hC020);
    put(16'h0A, 16'hD002);
    put(16'h0C, 16'hC000);
    put(16'h0E, 16'hD0FB); // BR -5
    put(16'h10, 16'h2000);
    put(16'h12, 16'hEE12);
    do_reset();
    run(60, 1'b0);
    check(n_st == 1 && st_a[0] == 16'd3 && st_d[0] == 16'd3, "R9 negative offset", st_d[0], 16'd3);

    // sweep of SET/ADD/CMP/BR with an unused opcode in the stream
    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 17) begin
        clear_all();
        put(16'h00, {8'hE1, 8'(a)});
        put(16'h02, {8'hE2, 8'(b)});
        put(16'h04, 16'h71F0); // unused opcode
        put(16'h06, 16'h3312);
        put(16'h08, 16'h2300);
        put(16'h0A, 16'hC120);
        put(16'h0C, 16'hD001);
        put(16'h0E, 16'h2100);
        put(16'h10, 16'hEE10);
        do_reset();
        run(20, (a == b));
        check(n_st >= 1 && st_d[0] == 16'(a + b), "R4 R5 R3 sum", st_d[0], 16'(a + b));
        if (a == b)
          check(n_st == 1, "R8 R9 taken", 16'(n_st), 16'd1);
        else
          check(n_st == 2 && st_d[1] == 16'(a), "R8 R9 not taken", st_d[1], 16'(a));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule